// File: doc/BRIEF.md
# Circular Sequence Profiler

This block watches the stream of addresses that reach one cache set and measures how each reused address came back. It keeps a small recency stack ordered from most recently used to least recently used. Every entry holds an address and an age counter. The age counter counts the references seen since that address was last touched. When an address comes back, the block reports two values. The first is the number of distinct addresses in the sequence that the two references enclose. The second is the number of references in that sequence, counting both ends.

Each report is a registered one-cycle event. It also adds one to a two-dimensional histogram. The histogram has one row per distinct-count and one column per sequence length. Software or a debug engine reads it through an index port that returns data one cycle after the index. For a fixed distinct-count, adding up a row gives the plain stack-distance count for that depth. A synchronous clear empties the stack, the age counters and the histogram.

Top module: `cseq_profiler`

## Requirements
- R1: After reset the event output is low, every histogram cell reads 0 and the stack is empty, so the first reference to any address produces no event.
- R2: A reference to an address not in the stack produces no event. The address is placed at the most recent position with age 1, so repeating it at once reports d=1, n=2.
- R3: A reference that finds its address at stack position d (1 = most recent, 4 = least recent) reports that d and n = c+1, where c is the entry's age before the reference. The stream A,B,C,B,A reports (2,3) and then (3,5).
- R4: After a reuse, the matched entry moves to the most recent position with age 1. The entries that were above it move down one place, and every other valid entry ages by one.
- R5: A miss on a full stack of 4 entries evicts the least recent entry without an event. A later reference to the evicted address is a miss.
- R6: Ages stop at 15, so the reported n never exceeds 16. The value n=16 stands for every sequence of 16 or more references. An exact n=15 is still reported as 15.
- R7: ev_valid rises in the cycle after the clock edge that accepted the reference, and it stays high for exactly one cycle per reuse.
- R8: Each event adds one to histogram cell row d-1, column n-1, so the last column collects the n=16 overflow. A row summed over its columns equals the number of events at that depth. Cells stop at their maximum value.
- R9: rd_data returns the cell selected by rd_row and rd_col one clock after they are presented.
- R10: clr returns the stack, the ages and the histogram to the reset state. It takes priority over a reference in the same cycle, and that reference is dropped.
- R11: Cycles with in_valid low change nothing: ages do not advance and no event is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of stack and histogram |
| in_valid | input | 1 | A reference is present this cycle |
| in_addr | input | 16 | Address (tag) of the reference |
| ev_valid | output | 1 | One-cycle pulse announcing a circular sequence |
| ev_d | output | 3 | Distinct addresses in the sequence (1..4) |
| ev_n | output | 5 | References in the sequence (2..16, 16 = overflow) |
| rd_row | input | 2 | Histogram row select, d-1 |
| rd_col | input | 4 | Histogram column select, n-1 |
| rd_data | output | 32 | Selected histogram cell, one cycle later |

## Verification
The event fields appear one cycle after the clock edge that accepts a reference. The histogram takes that event one edge later, and a read adds one more edge. The bench drives every input on the falling edge and checks the event fields on the falling edge right after the accepting edge. It checks the pulse again one cycle later to confirm that it lasted one cycle. Before each histogram read the bench lets one full cycle pass, so the last update is in place, and then compares rd_data one cycle after presenting the index.

// File: rtl/cseq_pkg.sv
// Shared types for the circular sequence profiler.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cseq_pkg;

    // Classification of one cycle's reference against the recency stack
    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MISS = 2'd1,
        ACC_HIT  = 2'd2
    } acc_kind_e;

endpackage

// File: rtl/cseq_stack.sv
// Recency stack with a per-entry age counter. Each reference is matched
// against every entry. A match registers a (distinct-count, length) event,
// and the stack is then reordered so that the referenced address sits at
// the most recent slot.
// Assumes: addresses held in the stack are unique, and clr/rst_n are
// synchronous and take priority over in_valid.
module cseq_stack
    import cseq_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int AGE_W  = 4,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int D_W   = $clog2(DEPTH + 1),
    localparam int N_W   = AGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              ev_valid,
    output logic [D_W-1:0]    ev_d,
    output logic [N_W-1:0]    ev_n
);

    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};
    localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

    logic [DEPTH-1:0]  vld_q;
    logic [ADDR_W-1:0] addr_q  [DEPTH];
    logic [AGE_W-1:0]  age_q   [DEPTH];
    logic [AGE_W-1:0]  age_inc [DEPTH];
    logic [DEPTH-1:0]  hit_vec;
    logic              hit;
    logic [POS_W-1:0]  hit_pos;
    logic [AGE_W-1:0]  hit_age;
    acc_kind_e         kind;

    logic              ev_valid_q;
    logic [D_W-1:0]    ev_d_q;
    logic [N_W-1:0]    ev_n_q;

    // Per-entry tag compare and saturating age step
    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign hit_vec[g] = vld_q[g] && (addr_q[g] == in_addr);
        assign age_inc[g] = (age_q[g] == AGE_MAX) ? age_q[g] : age_q[g] + AGE_ONE;
    end

    // Locate the matching position and the age it held before this reference
    always_comb begin
        hit_pos = '0;
        hit_age = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_pos = POS_W'(i);
                hit_age = age_q[i];
            end
        end
    end

    assign hit = |hit_vec;

    // Classify this cycle's reference
    always_comb begin
        if (!in_valid)  kind = ACC_NONE;
        else if (hit)   kind = ACC_HIT;
        else            kind = ACC_MISS;
    end

    // Reorder the stack: shift down to the matched slot (or fully on a miss),
    // age the entries below it, insert the reference at the top with age 1
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                age_q[i]  <= '0;
            end
        end else if (kind != ACC_NONE) begin
            vld_q[0]  <= 1'b1;
            addr_q[0] <= in_addr;
            age_q[0]  <= AGE_ONE;
            for (int i = 1; i < DEPTH; i++) begin
                if (kind == ACC_MISS || i <= int'(hit_pos)) begin
                    vld_q[i]  <= vld_q[i-1];
                    addr_q[i] <= addr_q[i-1];
                    age_q[i]  <= age_inc[i-1];
                end else begin
                    age_q[i]  <= age_inc[i];
                end
            end
        end
    end

    // Register the event fields for a reuse
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ev_valid_q <= 1'b0;
            ev_d_q     <= '0;
            ev_n_q     <= '0;
        end else begin
            ev_valid_q <= (kind == ACC_HIT);
            if (kind == ACC_HIT) begin
                ev_d_q <= D_W'(hit_pos) + D_W'(1);
                ev_n_q <= {1'b0, hit_age} + N_W'(1);
            end
        end
    end

    assign ev_valid = ev_valid_q;
    assign ev_d     = ev_d_q;
    assign ev_n     = ev_n_q;

    // R3
    hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> $onehot0(hit_vec));

    // R3
    ev_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_q |-> (ev_d_q >= D_W'(1) && ev_d_q <= D_W'(DEPTH)));

    // R6
    ev_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_q |-> (ev_n_q >= N_W'(2) && ev_n_q <= N_W'(2 ** AGE_W)));

    // R7
    ev_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid_q |-> $past(in_valid && !clr));

    // R10
    clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> !ev_valid_q);

endmodule

// File: rtl/cseq_hist.sv
// Two-dimensional histogram of circular sequence events. Row = d-1 and
// column = n-1. Lengths past the last column are already folded to the top
// value by the stack, so they land in the last column. Cells saturate. The
// read port is registered.
// Assumes: ev_d lies in 1..DEPTH and ev_n in 2..2**AGE_W when ev_valid is high.
module cseq_hist #(
    parameter int DEPTH = 4,
    parameter int AGE_W = 4,
    parameter int CNT_W = 32,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int D_W   = $clog2(DEPTH + 1),
    localparam int N_W   = AGE_W + 1,
    localparam int NBINS = 2 ** AGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_valid,
    input  logic [D_W-1:0]   ev_d,
    input  logic [N_W-1:0]   ev_n,
    input  logic [POS_W-1:0] rd_row,
    input  logic [AGE_W-1:0] rd_col,
    output logic [CNT_W-1:0] rd_data
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q [DEPTH][NBINS];
    logic [POS_W-1:0] up_row;
    logic [AGE_W-1:0] up_col;
    logic [D_W-1:0]   d_m1;
    logic [N_W-1:0]   n_m1;
    logic [CNT_W-1:0] rd_q;

    // Map the event fields to a cell address
    always_comb begin
        d_m1   = ev_d - D_W'(1);
        n_m1   = ev_n - N_W'(1);
        up_row = d_m1[POS_W-1:0];
        up_col = n_m1[AGE_W-1:0];
    end

    // Saturating increment of the addressed cell
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int r = 0; r < DEPTH; r++)
                for (int c = 0; c < NBINS; c++)
                    cnt_q[r][c] <= '0;
        end else if (ev_valid && cnt_q[up_row][up_col] != CNT_MAX) begin
            cnt_q[up_row][up_col] <= cnt_q[up_row][up_col] + CNT_W'(1);
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n || clr) rd_q <= '0;
        else               rd_q <= cnt_q[rd_row][rd_col];
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/cseq_profiler.sv
// Top level of the per-set circular sequence profiler. It joins the recency
// stack, which emits (d, n) events, to the histogram that counts them.
// Assumes: one reference per cycle at most, and synchronous control inputs.
module cseq_profiler #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 16,
    parameter int AGE_W  = 4,
    parameter int CNT_W  = 32,
    localparam int POS_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int D_W   = $clog2(DEPTH + 1),
    localparam int N_W   = AGE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              ev_valid,
    output logic [D_W-1:0]    ev_d,
    output logic [N_W-1:0]    ev_n,
    input  logic [POS_W-1:0]  rd_row,
    input  logic [AGE_W-1:0]  rd_col,
    output logic [CNT_W-1:0]  rd_data
);

    logic           s_ev_valid;
    logic [D_W-1:0] s_ev_d;
    logic [N_W-1:0] s_ev_n;

    cseq_stack #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .in_addr  (in_addr),
        .ev_valid (s_ev_valid),
        .ev_d     (s_ev_d),
        .ev_n     (s_ev_n)
    );

    cseq_hist #(.DEPTH(DEPTH), .AGE_W(AGE_W), .CNT_W(CNT_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .ev_valid (s_ev_valid),
        .ev_d     (s_ev_d),
        .ev_n     (s_ev_n),
        .rd_row   (rd_row),
        .rd_col   (rd_col),
        .rd_data  (rd_data)
    );

    assign ev_valid = s_ev_valid;
    assign ev_d     = s_ev_d;
    assign ev_n     = s_ev_n;

endmodule

// File: tb/cseq_profiler_tb.sv
// Directed bench for cseq_profiler: one task per scenario, each checking its
// own results. Inputs change on the falling edge, outputs are sampled there.
module cseq_profiler_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_addr = '0;
    logic        ev_valid;
    logic [2:0]  ev_d;
    logic [4:0]  ev_n;
    logic [1:0]  rd_row = '0;
    logic [3:0]  rd_col = '0;
    logic [31:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cseq_profiler u_dut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .in_valid(in_valid), .in_addr(in_addr),
        .ev_valid(ev_valid), .ev_d(ev_d), .ev_n(ev_n),
        .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
    );

    // Count one check and report a mismatch
    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // One reference, then sample the event fields on the next falling edge
    task automatic access(input logic [15:0] a);
        in_valid = 1'b1;
        in_addr  = a;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_ev(input string req, input bit v, input int d, input int n);
        chk({req, " ev_valid"}, ev_valid, v);
        if (v) begin
            chk({req, " ev_d"}, ev_d, d);
            chk({req, " ev_n"}, ev_n, n);
        end
    endtask

    task automatic idle(input int cycles);
        repeat (cycles) begin @(posedge clk); @(negedge clk); end
    endtask

    // Wait for pending histogram updates, then read one cell
    task automatic read_cell(input int row, input int col, output int val);
        idle(1);
        rd_row = 2'(row);
        rd_col = 4'(col);
        @(posedge clk);
        @(negedge clk);
        val = int'(rd_data);
    endtask

    task automatic do_clear();
        clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        int v;
        chk("R1 reset ev_valid", ev_valid, 0);
        read_cell(0, 1, v); chk("R1 reset cell(0,1)", v, 0);
        read_cell(3, 15, v); chk("R1 reset cell(3,15)", v, 0);
    endtask

    task automatic t_basic();
        int v, sum;
        access(16'hA); expect_ev("R2 miss A", 0, 0, 0);
        access(16'hB); expect_ev("R2 miss B", 0, 0, 0);
        access(16'hC); expect_ev("R2 miss C", 0, 0, 0);
        access(16'hB); expect_ev("R3 B", 1, 2, 3);
        idle(1);       expect_ev("R7 pulse ends", 0, 0, 0);
        access(16'hA); expect_ev("R3 A", 1, 3, 5);
        access(16'hB); expect_ev("R4 B after reorder", 1, 2, 3);
        access(16'hA); expect_ev("R4 A after reorder", 1, 2, 3);
        access(16'hA); expect_ev("R2 immediate repeat", 1, 1, 2);
        read_cell(1, 2, v); chk("R8 cell d2 n3", v, 3);
        read_cell(2, 4, v); chk("R8 cell d3 n5", v, 1);
        read_cell(0, 1, v); chk("R8 cell d1 n2", v, 1);
        sum = 0;
        for (int c = 0; c < 16; c++) begin read_cell(1, c, v); sum += v; end
        chk("R8 row d2 sum", sum, 3);
        // R9: index change seen exactly one edge later
        rd_row = 2'd2; rd_col = 4'd4;
        @(posedge clk); @(negedge clk);
        chk("R9 latency", rd_data, 1);
    endtask

    task automatic t_clear();
        int v;
        do_clear();
        read_cell(1, 2, v); chk("R10 cell cleared", v, 0);
        access(16'hA); expect_ev("R10 stack emptied", 0, 0, 0);
        in_valid = 1'b1; in_addr = 16'h77; clr = 1'b1;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0; clr = 1'b0;
        chk("R10 clr beats access", ev_valid, 0);
        access(16'h77); expect_ev("R10 dropped ref not stored", 0, 0, 0);
    endtask

    task automatic t_evict();
        do_clear();
        access(16'h1); access(16'h2); access(16'h3); access(16'h4);
        access(16'h5); expect_ev("R5 evicting miss", 0, 0, 0);
        access(16'h1); expect_ev("R5 evicted addr misses", 0, 0, 0);
        access(16'h3); expect_ev("R5 LRU reuse", 1, 4, 5);
    endtask

    task automatic t_saturate();
        int v;
        do_clear();
        access(16'hA);
        for (int i = 0; i < 13; i++) access(16'hB);
        access(16'hA); expect_ev("R6 exact n15", 1, 2, 15);
        access(16'hB);
        for (int i = 0; i < 20; i++) access(16'hA);
        access(16'hB); expect_ev("R6 saturated n16", 1, 2, 16);
        read_cell(1, 14, v); chk("R6 cell n15", v, 1);
        read_cell(1, 15, v); chk("R6 overflow cell", v, 1);
    endtask

    task automatic t_idle();
        do_clear();
        access(16'h9);
        for (int i = 0; i < 5; i++) begin in_addr = 16'(i + 40); idle(1); end
        chk("R11 no event when idle", ev_valid, 0);
        access(16'h9); expect_ev("R11 no aging when idle", 1, 1, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_clear();
        t_evict();
        t_saturate();
        t_idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule